// File: doc/BRIEF.md
# DDR Octal Memory Bus Master

This block is the host side of a low-pin-count double-data-rate memory bus. The bus has an active-low chip select, a clock generated by the block, an 8-bit data bus split into output, output-enable and input (the pad ring joins them), and a read strobe that the memory drives. The bus moves one byte on each clock edge, so one bus clock carries one 16-bit word. The bus clock runs at half the system clock rate. It toggles on the falling system edge, while bytes are launched on the rising system edge. Each byte therefore sits centred on the clock edge that carries it.

A user issues one request at a time: direction, burst type, a 16-bit word address, a word count and a latency setting. The block sends a three-clock command/address phase. On a write it then streams the words taken from `wr_data`. On a read it releases the bus, waits the initial latency, keeps the clock running for the requested number of words and rebuilds each word from the bytes that come with the strobe transitions. After the last word it raises chip select and pulses `done` with the bus already released.

Read strobe capture is synchronous. The strobe and data inputs are registered on the system clock, and each change of the registered strobe loads one byte. A capture window derived from the latency counter decides which strobe changes count.

Top module: `octbus_master`

## Requirements
- R1: After reset and between transactions: `bus_cs_n`=1, `bus_ck`=0, `bus_dq_oe`=0, `done`=0, `rd_valid`=0, and `req_ready`=1 only while idle.
- R2: The command/address phase is 48 bits over 6 bytes in 3 bus clocks, most significant byte first, with the first byte on a rising clock edge. Bit 47 is 1 for read and 0 for write. Bit 46 is 1 for linear and 0 for wrapped. Bits 45:16 hold the half-page address (word address shifted right by 3, zero-extended). Bits 15:3 are zero. Bits 2:0 hold the start word within the 16-byte half-page.
- R3: The bus clock has a period of two system clocks and idles low while chip select is high. Each of its edges falls while the system clock is low, half a system period after the byte was launched. A write has 3+N rising edges and a read has 3+L+N, where N is the word count and L is the latency.
- R4: A write sends N = `req_len`+1 words right after the command/address phase, upper byte on the rising edge and lower byte on the falling edge. `wr_ack` high in a cycle means `wr_data` is taken at the next rising system edge.
- R5: Strobe activity during a write produces no `rd_valid`.
- R6: The latency L is `cfg_latency` clamped to the range 5..16 and sampled when the request is accepted. Read data starts on the bus clock that follows 3+L clocks.
- R7: On a read, a rising strobe transition loads the upper byte and a falling transition loads the lower byte. The completed word appears on `rd_data` with `rd_valid` high for one cycle.
- R8: Strobe transitions during the initial latency are ignored.
- R9: Wrapped and linear reads both end after exactly N words, when chip select is driven high.
- R10: `done` is a one-cycle pulse, given with `bus_dq_oe`=0 and `bus_cs_n`=1. Chip select stays high for at least 2 system clocks between transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_latency | input | LAT_W | Requested initial latency in bus clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted at the next edge |
| req_read | input | 1 | 1 read, 0 write |
| req_linear | input | 1 | 1 linear burst, 0 wrapped burst |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Word count minus one |
| wr_data | input | 16 | Write word |
| wr_ack | output | 1 | Write word taken at next edge |
| rd_data | output | 16 | Read word |
| rd_valid | output | 1 | Read word valid |
| done | output | 1 | Transaction finished |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ck | output | 1 | Bus clock |
| bus_dq_out | output | 8 | Data bus output byte |
| bus_dq_oe | output | 1 | Data bus output enable |
| bus_dq_in | input | 8 | Data bus input byte |
| bus_rwds_in | input | 1 | Read strobe from memory |

## Verification
Writes of one and five words check byte order and clock counts. Wrapped and linear bursts, and an address at the top of the range, show that the burst type changes only bit 46 and never the length. Latency settings of 5, 7, 16, one below the range and one above it, a setting changed after acceptance, and a memory model that uses the clamped value tell apart correct clamping and sampling from a latency count that is one clock off. Strobe pulses during the latency, and strobe toggling on every cycle of a write, show that the capture window rejects activity outside the read data phase.

// File: rtl/octbus_pkg.sv
package octbus_pkg;

    localparam int CA_BITS  = 48;
    localparam int CA_BYTES = CA_BITS / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CA,
        ST_WR,
        ST_RD,
        ST_DRAIN,
        ST_GAP
    } bus_state_e;

endpackage

// File: rtl/octbus_ca_gen.sv
module octbus_ca_gen #(
    parameter int ADDR_W = 24
) (
    input  logic              is_read,
    input  logic              is_linear,
    input  logic [ADDR_W-1:0] word_addr,
    output logic [47:0]       ca
);
    localparam int OFF_W = 3;
    localparam int HP_W  = ADDR_W - OFF_W;

    // R2: direction, burst type, half-page address, start word in half-page
    always_comb begin
        ca              = '0;
        ca[47]          = is_read;
        ca[46]          = is_linear;
        ca[16 +: HP_W]  = word_addr[ADDR_W-1:OFF_W];
        ca[OFF_W-1:0]   = word_addr[OFF_W-1:0];
    end
endmodule

// File: rtl/octbus_ck_gen.sv
module octbus_ck_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ck
);
    logic ck_d, ck_q;

    // Toggles on the falling system edge so that every bus clock edge sits
    // half a system period after the byte launched on the rising edge.
    always_comb begin
        ck_d = run ? ~ck_q : 1'b0;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) ck_q <= 1'b0;
        else        ck_q <= ck_d;
    end

    assign ck = ck_q;
endmodule

// File: rtl/octbus_rd_capture.sv
module octbus_rd_capture (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        win,
    input  logic [7:0]  dq_in,
    input  logic        rwds_in,
    output logic [15:0] rd_data,
    output logic        rd_valid
);
    typedef struct packed {
        logic        strb_s;
        logic        strb_p;
        logic [7:0]  dq_s;
        logic [7:0]  hi;
        logic [15:0] word;
        logic        valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d        = cap_q;
        cap_d.strb_s = rwds_in;
        cap_d.dq_s   = dq_in;
        cap_d.strb_p = cap_q.strb_s;
        cap_d.valid  = 1'b0;
        if (win && (cap_q.strb_s != cap_q.strb_p)) begin
            if (cap_q.strb_s) begin
                cap_d.hi = cap_q.dq_s;
            end else begin
                cap_d.word  = {cap_q.hi, cap_q.dq_s};
                cap_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_data  = cap_q.word;
    assign rd_valid = cap_q.valid;

    // R5 / R8: a word is only produced from a strobe edge inside the window
    a_r8_capture_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.valid |-> $past(win));
endmodule

// File: rtl/octbus_master.sv
module octbus_master #(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 8,
    parameter int LAT_W   = 5,
    parameter int LAT_MIN = 5,
    parameter int LAT_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic              req_linear,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [15:0]       wr_data,
    output logic              wr_ack,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              bus_cs_n,
    output logic              bus_ck,
    output logic [7:0]        bus_dq_out,
    output logic              bus_dq_oe,
    input  logic [7:0]        bus_dq_in,
    input  logic              bus_rwds_in
);
    import octbus_pkg::*;

    localparam int CA_PH  = 2 * CA_BYTES / 2;
    localparam int PH_MAX = 2 * LAT_MAX + 2 * (2 ** LEN_W);
    localparam int CNT_W  = $clog2(PH_MAX + 1);

    typedef struct packed {
        bus_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [CA_BITS-1:0] ca;
        logic               rd;
        logic [LEN_W-1:0]   len;
        logic [LAT_W-1:0]   lat;
        logic [7:0]         lo;
        logic [7:0]         dq;
        logic               oe;
        logic               cs_n;
        logic               run;
        logic               done;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [CA_BITS-1:0] ca_new;
    logic [LAT_W-1:0]   lat_eff;
    logic [CNT_W-1:0]   lat_ph, wr_last, rd_last;
    logic               win_d;
    logic               ack_d;

    octbus_ca_gen #(.ADDR_W(ADDR_W)) i_ca_gen (
        .is_read   (req_read),
        .is_linear (req_linear),
        .word_addr (req_addr),
        .ca        (ca_new)
    );

    // R6: clamp the requested latency into the supported range
    always_comb begin
        if (cfg_latency < LAT_W'(LAT_MIN))      lat_eff = LAT_W'(LAT_MIN);
        else if (cfg_latency > LAT_W'(LAT_MAX)) lat_eff = LAT_W'(LAT_MAX);
        else                                    lat_eff = cfg_latency;
    end

    always_comb begin
        lat_ph  = CNT_W'({fsm_q.lat, 1'b0});
        wr_last = CNT_W'({fsm_q.len, 1'b1});
        rd_last = lat_ph + CNT_W'({fsm_q.len, 1'b1});
    end

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        win_d      = 1'b0;
        ack_d      = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                fsm_d.cs_n = 1'b1;
                fsm_d.oe   = 1'b0;
                fsm_d.run  = 1'b0;
                if (req_valid) begin
                    fsm_d.st   = ST_CA;
                    fsm_d.cnt  = '0;
                    fsm_d.rd   = req_read;
                    fsm_d.len  = req_len;
                    fsm_d.lat  = lat_eff;
                    fsm_d.dq   = ca_new[CA_BITS-1 -: 8];
                    fsm_d.ca   = ca_new << 8;
                    fsm_d.oe   = 1'b1;
                    fsm_d.cs_n = 1'b0;
                    fsm_d.run  = 1'b1;
                end
            end
            ST_CA: begin
                if (fsm_q.cnt == CNT_W'(CA_BYTES - 1)) begin
                    fsm_d.cnt = '0;
                    if (fsm_q.rd) begin
                        fsm_d.st = ST_RD;
                        fsm_d.oe = 1'b0;
                        fsm_d.dq = '0;
                    end else begin
                        fsm_d.st = ST_WR;
                        fsm_d.dq = wr_data[15:8];
                        fsm_d.lo = wr_data[7:0];
                        ack_d    = 1'b1;
                    end
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                    fsm_d.dq  = fsm_q.ca[CA_BITS-1 -: 8];
                    fsm_d.ca  = fsm_q.ca << 8;
                end
            end
            ST_WR: begin
                if (!fsm_q.cnt[0]) begin
                    fsm_d.dq  = fsm_q.lo;
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end else if (fsm_q.cnt == wr_last) begin
                    fsm_d.st   = ST_GAP;
                    fsm_d.cnt  = '0;
                    fsm_d.cs_n = 1'b1;
                    fsm_d.oe   = 1'b0;
                    fsm_d.run  = 1'b0;
                    fsm_d.dq   = '0;
                    fsm_d.done = 1'b1;
                end else begin
                    fsm_d.dq  = wr_data[15:8];
                    fsm_d.lo  = wr_data[7:0];
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                    ack_d     = 1'b1;
                end
            end
            ST_RD: begin
                win_d = (fsm_q.cnt > lat_ph);
                if (fsm_q.cnt == rd_last) begin
                    fsm_d.st  = ST_DRAIN;
                    fsm_d.cnt = '0;
                    fsm_d.run = 1'b0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_DRAIN: begin
                win_d = 1'b1;
                if (fsm_q.cnt == CNT_W'(1)) begin
                    fsm_d.st   = ST_GAP;
                    fsm_d.cnt  = '0;
                    fsm_d.cs_n = 1'b1;
                    fsm_d.done = 1'b1;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (fsm_q.cnt == CNT_W'(1)) begin
                    fsm_d.st  = ST_IDLE;
                    fsm_d.cnt = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q      <= '0;
            fsm_q.cs_n <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    octbus_ck_gen i_ck_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (fsm_q.run),
        .ck    (bus_ck)
    );

    octbus_rd_capture i_rd_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .win      (win_d),
        .dq_in    (bus_dq_in),
        .rwds_in  (bus_rwds_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign req_ready  = (fsm_q.st == ST_IDLE);
    assign wr_ack     = ack_d;
    assign done       = fsm_q.done;
    assign bus_cs_n   = fsm_q.cs_n;
    assign bus_dq_out = fsm_q.dq;
    assign bus_dq_oe  = fsm_q.oe;

    a_r10_done_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_dq_oe && bus_cs_n));

    a_r10_cs_high_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |=> bus_cs_n);

    a_r3_ck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> !bus_ck);

    a_r4_drive_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dq_oe |-> !bus_cs_n);

    a_r1_ready_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && !bus_dq_oe && !done));

    a_r4_ack_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (!bus_cs_n && bus_dq_oe));
endmodule

// File: tb/test_octbus_master.sv
`timescale 1ns/1ps
module test_octbus_master;
    localparam int ADDR_W = 24;
    localparam int LEN_W  = 8;
    localparam int LAT_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LAT_W-1:0]  cfg_latency = 5'd5;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_read = 1'b0;
    logic              req_linear = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [15:0]       wr_data = '0;
    logic              wr_ack;
    logic [15:0]       rd_data;
    logic              rd_valid;
    logic              done;
    logic              bus_cs_n;
    logic              bus_ck;
    logic [7:0]        bus_dq_out;
    logic              bus_dq_oe;
    logic [7:0]        bus_dq_in = '0;
    logic              bus_rwds_in = 1'b0;

    always #2.5 clk = ~clk;

    octbus_master #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LAT_W(LAT_W)) i_octbus_master (
        .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_linear(req_linear), .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_ack(wr_ack), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .bus_cs_n(bus_cs_n), .bus_ck(bus_ck), .bus_dq_out(bus_dq_out),
        .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in), .bus_rwds_in(bus_rwds_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // ---------------- bus monitors ----------------
    logic [7:0] bytes_seen [0:127];
    int   nb = 0;
    int   ck_cnt = 0;
    realtime last_rise = -1.0;
    int   ck_bad_period = 0;
    int   ck_bad_phase = 0;

    always @(negedge bus_cs_n) begin
        nb = 0;
        ck_cnt = 0;
        last_rise = -1.0;
    end

    always @(posedge bus_ck) begin
        ck_cnt++;
        if (last_rise >= 0.0 && ($realtime - last_rise) != 10.0) ck_bad_period++;
        last_rise = $realtime;
        if (clk !== 1'b0) ck_bad_phase++;
        if (!bus_cs_n && bus_dq_oe && nb < 128) begin bytes_seen[nb] = bus_dq_out; nb++; end
    end

    always @(negedge bus_ck) begin
        if (clk !== 1'b0) ck_bad_phase++;
        if (!bus_cs_n && bus_dq_oe && nb < 128) begin bytes_seen[nb] = bus_dq_out; nb++; end
    end

    logic [15:0] rd_buf [0:63];
    int rd_n = 0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (rd_n < 64) rd_buf[rd_n] = rd_data;
            rd_n++;
        end
    end

    int hi_run = 0;
    int min_gap = 1000;
    bit seen_tx = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_cs_n) hi_run++;
            else begin
                if (hi_run > 0 && seen_tx && hi_run < min_gap) min_gap = hi_run;
                if (hi_run > 0) seen_tx = 1'b1;
                hi_run = 0;
            end
        end
    end

    // write data feeder
    logic [15:0] wr_words [0:31];
    int  wr_idx = 0;
    bit  wr_pend = 1'b0;
    always @(negedge clk) begin
        if (wr_pend) wr_idx++;
        wr_pend = wr_ack;
        wr_data = wr_words[wr_idx % 32];
    end

    // ---------------- helpers ----------------
    function automatic logic [47:0] exp_ca(input bit rd, input bit lin, input logic [ADDR_W-1:0] a);
        logic [47:0] e;
        e = '0;
        e[47] = rd;
        e[46] = lin;
        e[16 +: ADDR_W-3] = a[ADDR_W-1:3];
        e[2:0] = a[2:0];
        return e;
    endfunction

    function automatic logic [7:0] rd_hi(input int k);
        return 8'(8'h3C + 7 * k);
    endfunction

    function automatic logic [7:0] rd_lo(input int k);
        return 8'(8'hA1 ^ k);
    endfunction

    task automatic check_ca(input bit rd, input bit lin, input logic [ADDR_W-1:0] a);
        logic [47:0] e;
        logic [47:0] got;
        e = exp_ca(rd, lin, a);
        got = {bytes_seen[0], bytes_seen[1], bytes_seen[2], bytes_seen[3], bytes_seen[4], bytes_seen[5]};
        chk(got == e, "R2", "command/address bytes", got, e);
    endtask

    // issues a request and waits for done; checks the done pulse (R10)
    task automatic issue(input bit rd, input bit lin, input logic [ADDR_W-1:0] a,
                         input int n, input logic [LAT_W-1:0] cfg, input logic [LAT_W-1:0] cfg_after);
        @(negedge clk);
        req_read = rd; req_linear = lin; req_addr = a; req_len = LEN_W'(n - 1);
        cfg_latency = cfg;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_latency = cfg_after;
        while (!done) @(negedge clk);
        chk(!bus_dq_oe && bus_cs_n, "R10", "bus released at done", {bus_dq_oe, bus_cs_n}, 2'b01);
        @(negedge clk);
        chk(!done, "R10", "done is one cycle", done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n && !bus_ck && !bus_dq_oe, "R1", "idle bus after reset",
            {bus_cs_n, bus_ck, bus_dq_oe}, 3'b100);
        chk(req_ready && !done && !rd_valid, "R1", "idle handshake after reset",
            {req_ready, done, rd_valid}, 3'b100);
    endtask

    task automatic t_write(input logic [ADDR_W-1:0] a, input bit lin, input int n, input bit noise);
        bit fin;
        @(posedge clk);
        for (int k = 0; k < 32; k++) wr_words[k] = {8'(8'h11 * (k + 1)), 8'(8'hE0 + k)};
        wr_idx = 0;
        rd_n = 0;
        fin = 1'b0;
        fork
            begin
                issue(1'b0, lin, a, n, 5'd5, 5'd5);
                fin = 1'b1;
            end
            begin
                while (noise && !fin) begin
                    @(negedge clk);
                    bus_rwds_in = ~bus_rwds_in;
                    bus_dq_in = bus_dq_in + 8'h13;
                end
            end
        join
        bus_rwds_in = 1'b0;
        check_ca(1'b0, lin, a);
        chk(nb == 6 + 2 * n, "R4", "bytes driven on write", nb, 6 + 2 * n);
        for (int k = 0; k < n; k++) begin
            chk({bytes_seen[6 + 2 * k], bytes_seen[7 + 2 * k]} == wr_words[k], "R4",
                "write word upper-then-lower", {bytes_seen[6 + 2 * k], bytes_seen[7 + 2 * k]}, wr_words[k]);
        end
        chk(ck_cnt == 3 + n, "R3", "clock count on write", ck_cnt, 3 + n);
        if (noise) chk(rd_n == 0, "R5", "no read word during write strobe noise", rd_n, 0);
    endtask

    task automatic t_read(input logic [ADDR_W-1:0] a, input bit lin, input int n,
                          input logic [LAT_W-1:0] cfg, input logic [LAT_W-1:0] cfg_after,
                          input int lat, input bit noise);
        @(posedge clk);
        rd_n = 0;
        fork
            issue(1'b1, lin, a, n, cfg, cfg_after);
            begin
                @(negedge bus_cs_n);
                repeat (3) @(posedge bus_ck);
                for (int i = 0; i < lat; i++) begin
                    @(posedge bus_ck);
                    bus_dq_in = 8'hEE;
                    if (noise && i == 1) bus_rwds_in = 1'b1;
                    if (noise && i == 2) bus_rwds_in = 1'b0;
                end
                for (int k = 0; k < n; k++) begin
                    @(posedge bus_ck);
                    bus_dq_in = rd_hi(k);
                    bus_rwds_in = 1'b1;
                    @(negedge bus_ck);
                    bus_dq_in = rd_lo(k);
                    bus_rwds_in = 1'b0;
                end
                @(posedge bus_cs_n);
                bus_dq_in = 8'h00;
            end
        join
        check_ca(1'b1, lin, a);
        chk(nb == 6, "R2", "bytes driven on read", nb, 6);
        chk(ck_cnt == 3 + lat + n, "R6", "clock count on read (latency)", ck_cnt, 3 + lat + n);
        chk(rd_n == n, noise ? "R8" : "R9", "read word count", rd_n, n);
        for (int k = 0; k < n && k < 64; k++) begin
            chk(rd_buf[k] == {rd_hi(k), rd_lo(k)}, "R7", "read word value", rd_buf[k], {rd_hi(k), rd_lo(k)});
        end
    endtask

    // ---------------- main ----------------
    bit finished = 1'b0;

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write(24'h012345, 1'b0, 1, 1'b0);                  // R2 R4 wrapped single word
        t_write(24'h00ABC7, 1'b1, 5, 1'b1);                  // R4 R5 linear, strobe noise
        t_read (24'h000013, 1'b1, 4, 5'd5, 5'd5, 5, 1'b0);   // R6 R7 minimum latency
        t_read (24'h1F0F0A, 1'b0, 8, 5'd16, 5'd16, 16, 1'b1);// R8 R9 wrapped, max latency, noise
        t_read (24'h000101, 1'b1, 3, 5'd3, 5'd9, 5, 1'b0);   // R6 clamp low, sampled at accept
        t_read (24'h000202, 1'b1, 2, 5'd20, 5'd20, 16, 1'b0);// R6 clamp high
        t_read (24'hFFFFFF, 1'b1, 20, 5'd7, 5'd7, 7, 1'b1);  // R9 linear long, top address
        chk(ck_bad_period == 0, "R3", "bus clock period two system clocks", ck_bad_period, 0);
        chk(ck_bad_phase == 0, "R3", "bus clock edges while system clock low", ck_bad_phase, 0);
        chk(min_gap >= 2, "R10", "chip select high gap", min_gap, 2);
        @(negedge clk);
        chk(bus_cs_n && !bus_ck && !bus_dq_oe && req_ready, "R1", "idle bus at end",
            {bus_cs_n, bus_ck, bus_dq_oe, req_ready}, 4'b1001);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule